// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address and classifies the fetch as a hit, an access violation or a page fault. Each request carries the virtual address, the fetch PC, the current privilege mode and the current address-space number. The result comes back one clock after the request. A small fully associative table of page entries is filled through a plain write port by the agent that owns page management. The block itself never walks page tables and never chooses a victim entry.

Three paths exist, tried in a fixed order. A fetch PC with its least significant bit set marks privileged code, and its address passes straight through. A fixed high virtual window, the superpage, maps directly onto physical space, but only in kernel mode. Every other address goes through the table, where the matching entry also has to grant execute permission for the current mode. Saturating counters keep a running record of hits, misses, violations and total accesses.

Top module: `ifetch_xlate`

## Requirements
- R1: A response (`rsp_valid` high) appears exactly one clock after each cycle with `req_valid` high, and `rsp_valid` is low one clock after a cycle with `req_valid` low. After reset `rsp_valid` is low and all counters read zero.
- R2: When `req_pc[0]` is 1, the result is a hit whose physical address is `{req_va[43:2], 2'b00}`. This takes priority over every other check, the virtual-address check included.
- R3: When `req_pc[0]` is 0 and `req_va[63:47]` is neither all ones nor all zeros, the result is an access violation.
- R4: A valid address with `req_va[47:41]` equal to 7'h7E is a superpage. In mode 0 (kernel) it is a hit, and the physical address is `req_va[43:0]` with bits 43:40 replaced by 4'hF when `req_va[40]` is 1, or by 4'h0 when it is 0. No table lookup takes place.
- R5: A superpage access in mode 1, 2 or 3 is an access violation.
- R6: Any other valid address hits a table entry when that entry is valid, its page number equals `req_va[47:13]` and its address-space number equals `req_asn`. The physical address is then `{pfn, req_va[12:0]}`. When several entries match, the lowest index wins.
- R7: A table lookup with no matching entry is a page fault.
- R8: A matching entry whose execute-mask bit indexed by `req_mode` is 0 gives an access violation.
- R9: Result codes are 0 for a hit, 1 for an access violation and 2 for a page fault. On a fault, `rsp_pa` is zero.
- R10: `cnt_hit`, `cnt_miss` and `cnt_viol` each count one per hit, page fault or access violation. Each stops at its all-ones value.
- R11: `cnt_access` counts one per hit or page fault. It therefore equals `cnt_hit + cnt_miss` until it saturates at all ones.
- R12: A write through the table port takes effect at the clock edge. A request in the same cycle as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_va | input | 64 | Fetch virtual address |
| req_pc | input | 64 | Fetch PC; bit 0 marks privileged code |
| req_mode | input | 2 | Mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| req_asn | input | ASN_W | Current address-space number |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | 35 | Virtual page number (VA bits 47:13) |
| wr_asn | input | ASN_W | Entry address-space number |
| wr_pfn | input | 31 | Physical frame number (PA bits 43:13) |
| wr_valid | input | 1 | Entry valid bit |
| wr_xmask | input | 4 | Execute enable, one bit per mode |
| rsp_valid | output | 1 | Result present |
| rsp_pa | output | 44 | Physical address |
| rsp_code | output | 2 | Result code |
| cnt_hit | output | CNT_W | Hit counter |
| cnt_miss | output | CNT_W | Page-fault counter |
| cnt_viol | output | CNT_W | Access-violation counter |
| cnt_access | output | CNT_W | Hit-plus-miss counter |

## Verification
The hardest states to reach from the ports are the ones where timing or ordering, not a single address, decides the result. One is a lookup issued in the same cycle that writes the matching entry. Another is two valid entries matching the same page. A third is counters sitting at their ceiling. The bench creates the first by driving a request alongside the write strobe, and the second by rewriting a lower index with the same page and a different frame, then invalidating it again. For the third it builds the block with narrow counters and streams a few hundred privileged-code fetches through it. A behavioural model predicts every response and every counter value on each clock.

// File: rtl/ifx_pkg.sv
package ifx_pkg;
  localparam int VA_W     = 64;
  localparam int PA_W     = 44;
  localparam int PG_BITS  = 13;
  localparam int VA_MSB   = 47;
  localparam int VPN_W    = VA_MSB + 1 - PG_BITS;
  localparam int PFN_W    = PA_W - PG_BITS;
  localparam int NMODES   = 4;
  localparam int MODE_W   = $clog2(NMODES);
  localparam logic [6:0]        SPG_TAG     = 7'h7E;
  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

  typedef enum logic [1:0] {
    RES_HIT = 2'd0,
    RES_ACV = 2'd1,
    RES_PGF = 2'd2
  } res_e;
endpackage

// File: rtl/ifx_sat_cnt.sv
module ifx_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en    = inc && (cnt_q != {W{1'b1}});
    cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ifx_xlt_table.sv
module ifx_xlt_table
  import ifx_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASN_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASN_W-1:0]  wr_asn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic [NMODES-1:0] wr_xmask,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [NMODES-1:0] lk_xmask
);
  logic [VPN_W-1:0]  e_vpn   [ENTRIES];
  logic [ASN_W-1:0]  e_asn   [ENTRIES];
  logic [PFN_W-1:0]  e_pfn   [ENTRIES];
  logic [NMODES-1:0] e_xmask [ENTRIES];
  logic [ENTRIES-1:0] e_vld;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic we;
    assign we = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  e_vld[i] <= 1'b0;
      else if (we) e_vld[i] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        e_vpn[i]   <= wr_vpn;
        e_asn[i]   <= wr_asn;
        e_pfn[i]   <= wr_pfn;
        e_xmask[i] <= wr_xmask;
      end
    end

    assign match[i] = e_vld[i] && (e_vpn[i] == lk_vpn) && (e_asn[i] == lk_asn);
  end

  // lowest matching index wins
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel = ENTRIES'(1) << i;
    end
  end

  always_comb begin
    lk_hit   = |match;
    lk_pfn   = '0;
    lk_xmask = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_pfn   = lk_pfn   | ({PFN_W{sel[i]}}  & e_pfn[i]);
      lk_xmask = lk_xmask | ({NMODES{sel[i]}} & e_xmask[i]);
    end
  end
endmodule

// File: rtl/ifx_classify.sv
module ifx_classify
  import ifx_pkg::*;
(
  input  logic [VA_W-1:0]   va,
  input  logic              pc_priv,
  input  logic [MODE_W-1:0] mode,
  input  logic              tbl_hit,
  input  logic [PFN_W-1:0]  tbl_pfn,
  input  logic [NMODES-1:0] tbl_xmask,
  output res_e              res,
  output logic [PA_W-1:0]   pa
);
  logic va_ok;
  logic spg;

  always_comb begin
    va_ok = (&va[VA_W-1:VA_MSB]) || !(|va[VA_W-1:VA_MSB]);
    spg   = (va[VA_MSB:VA_MSB-6] == SPG_TAG);
  end

  always_comb begin
    res = RES_ACV;
    pa  = '0;
    if (pc_priv) begin
      res = RES_HIT;
      pa  = {va[PA_W-1:2], 2'b00};
    end else if (!va_ok) begin
      res = RES_ACV;
    end else if (spg) begin
      if (mode == MODE_KERNEL) begin
        res = RES_HIT;
        pa  = {{4{va[40]}}, va[39:0]};
      end
    end else if (!tbl_hit) begin
      res = RES_PGF;
    end else if (tbl_xmask[mode]) begin
      res = RES_HIT;
      pa  = {tbl_pfn, va[PG_BITS-1:0]};
    end
  end
endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
  import ifx_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASN_W   = 8,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       req_va,
  input  logic [63:0]       req_pc,
  input  logic [1:0]        req_mode,
  input  logic [ASN_W-1:0]  req_asn,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [34:0]       wr_vpn,
  input  logic [ASN_W-1:0]  wr_asn,
  input  logic [30:0]       wr_pfn,
  input  logic              wr_valid,
  input  logic [3:0]        wr_xmask,
  output logic              rsp_valid,
  output logic [43:0]       rsp_pa,
  output logic [1:0]        rsp_code,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_viol,
  output logic [CNT_W-1:0]  cnt_access
);
  logic              tbl_hit;
  logic [PFN_W-1:0]  tbl_pfn;
  logic [NMODES-1:0] tbl_xmask;
  res_e              cls_res;
  logic [PA_W-1:0]   cls_pa;
  logic              unused_pc_bits;

  assign unused_pc_bits = ^req_pc[63:1];

  ifx_xlt_table #(.ENTRIES(ENTRIES), .ASN_W(ASN_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_vpn   (wr_vpn),
    .wr_asn   (wr_asn),
    .wr_pfn   (wr_pfn),
    .wr_valid (wr_valid),
    .wr_xmask (wr_xmask),
    .lk_vpn   (req_va[VA_MSB:PG_BITS]),
    .lk_asn   (req_asn),
    .lk_hit   (tbl_hit),
    .lk_pfn   (tbl_pfn),
    .lk_xmask (tbl_xmask)
  );

  ifx_classify u_cls (
    .va        (req_va),
    .pc_priv   (req_pc[0]),
    .mode      (req_mode),
    .tbl_hit   (tbl_hit),
    .tbl_pfn   (tbl_pfn),
    .tbl_xmask (tbl_xmask),
    .res       (cls_res),
    .pa        (cls_pa)
  );

  // response register
  logic            vld_q, vld_d;
  logic [PA_W-1:0] pa_q, pa_d;
  logic [1:0]      code_q, code_d;
  logic            inc_hit, inc_miss, inc_viol, inc_acc;

  always_comb begin
    vld_d    = req_valid;
    pa_d     = req_valid ? cls_pa : pa_q;
    code_d   = req_valid ? cls_res : code_q;
    inc_hit  = req_valid && (cls_res == RES_HIT);
    inc_miss = req_valid && (cls_res == RES_PGF);
    inc_viol = req_valid && (cls_res == RES_ACV);
    inc_acc  = inc_hit || inc_miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pa_q   <= '0;
      code_q <= RES_HIT;
    end else begin
      vld_q  <= vld_d;
      pa_q   <= pa_d;
      code_q <= code_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_pa    = pa_q;
  assign rsp_code  = code_q;

  ifx_sat_cnt #(.W(CNT_W)) u_c_hit  (.clk(clk), .rst_n(rst_n), .inc(inc_hit),  .cnt(cnt_hit));
  ifx_sat_cnt #(.W(CNT_W)) u_c_miss (.clk(clk), .rst_n(rst_n), .inc(inc_miss), .cnt(cnt_miss));
  ifx_sat_cnt #(.W(CNT_W)) u_c_viol (.clk(clk), .rst_n(rst_n), .inc(inc_viol), .cnt(cnt_viol));
  ifx_sat_cnt #(.W(CNT_W)) u_c_acc  (.clk(clk), .rst_n(rst_n), .inc(inc_acc),  .cnt(cnt_access));
endmodule

// File: rtl/ifx_chk.sv
module ifx_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [63:41]     va_hi,
  input logic             pc_lsb,
  input logic [1:0]       req_mode,
  input logic             rsp_valid,
  input logic [43:0]      rsp_pa,
  input logic [1:0]       rsp_code,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_miss,
  input logic [CNT_W-1:0] cnt_access
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  priv_pc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pc_lsb) |=> (rsp_code == 2'd0) && (rsp_pa[1:0] == 2'b00));

  // R3
  bad_va_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_lsb && !(&va_hi[63:47]) && (|va_hi[63:47])) |=> (rsp_code == 2'd1));

  // R5
  spg_user_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_lsb && (&va_hi[63:47]) && (va_hi[47:41] == 7'h7E) && (req_mode != 2'd0))
      |=> (rsp_code == 2'd1));

  // R9
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_code != 2'd0)) |-> (rsp_pa == 44'd0));

  // R9
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3));

  // R10
  hit_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_hit) == {CNT_W{1'b1}}) |-> (cnt_hit == {CNT_W{1'b1}}));

  // R11
  access_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_access != {CNT_W{1'b1}}) |->
      ({1'b0, cnt_access} == ({1'b0, cnt_hit} + {1'b0, cnt_miss})));
endmodule

bind ifetch_xlate ifx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .va_hi      (req_va[63:41]),
  .pc_lsb     (req_pc[0]),
  .req_mode   (req_mode),
  .rsp_valid  (rsp_valid),
  .rsp_pa     (rsp_pa),
  .rsp_code   (rsp_code),
  .cnt_hit    (cnt_hit),
  .cnt_miss   (cnt_miss),
  .cnt_access (cnt_access)
);

// File: tb/ifetch_xlate_tb.sv
module ifetch_xlate_tb;
  localparam int ENT  = 16;
  localparam int ASNW = 8;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            req_valid;
  logic [63:0]     req_va, req_pc;
  logic [1:0]      req_mode;
  logic [ASNW-1:0] req_asn;
  logic            wr_en;
  logic [3:0]      wr_idx;
  logic [34:0]     wr_vpn;
  logic [ASNW-1:0] wr_asn;
  logic [30:0]     wr_pfn;
  logic            wr_valid;
  logic [3:0]      wr_xmask;
  logic            rsp_valid;
  logic [43:0]     rsp_pa;
  logic [1:0]      rsp_code;
  logic [CW-1:0]   cnt_hit, cnt_miss, cnt_viol, cnt_access;

  ifetch_xlate #(.ENTRIES(ENT), .ASN_W(ASNW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_pc(req_pc),
    .req_mode(req_mode), .req_asn(req_asn), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_asn(wr_asn), .wr_pfn(wr_pfn), .wr_valid(wr_valid),
    .wr_xmask(wr_xmask), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_code(rsp_code),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_viol(cnt_viol), .cnt_access(cnt_access)
  );

  int errs = 0;
  int chks = 0;
  int cyc  = 0;

  // behavioural model state
  logic [34:0]     m_vpn [ENT];
  logic [ASNW-1:0] m_asn [ENT];
  logic [30:0]     m_pfn [ENT];
  logic [3:0]      m_x   [ENT];
  logic            m_v   [ENT];
  int m_hit, m_miss, m_viol, m_acc;
  logic        exp_v;
  logic [1:0]  exp_code;
  logic [43:0] exp_pa;
  string       exp_tag;
  string       force_tag = "";

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++;
      chks++;
      $display("FAIL R1 watchdog expired: actual=%0d cycles expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic predict();
    int hit_i = -1;
    exp_pa = '0;
    if (req_pc[0]) begin
      exp_code = 2'd0; exp_pa = {req_va[43:2], 2'b00}; exp_tag = "R2";
    end else if (!(req_va[63:47] == '1 || req_va[63:47] == '0)) begin
      exp_code = 2'd1; exp_tag = "R3";
    end else if (req_va[47:41] == 7'h7E) begin
      if (req_mode == 2'd0) begin
        exp_code = 2'd0; exp_pa = req_va[43:0];
        exp_pa[43:40] = req_va[40] ? 4'hF : 4'h0;
        exp_tag = "R4";
      end else begin
        exp_code = 2'd1; exp_tag = "R5";
      end
    end else begin
      for (int i = ENT - 1; i >= 0; i--)
        if (m_v[i] && m_vpn[i] == req_va[47:13] && m_asn[i] == req_asn) hit_i = i;
      if (hit_i < 0) begin
        exp_code = 2'd2; exp_tag = "R7";
      end else if (!m_x[hit_i][req_mode]) begin
        exp_code = 2'd1; exp_tag = "R8";
      end else begin
        exp_code = 2'd0; exp_pa = {m_pfn[hit_i], req_va[12:0]}; exp_tag = "R6";
      end
    end
    if (force_tag != "") exp_tag = force_tag;
    case (exp_code)
      2'd0: begin m_hit = sat(m_hit); m_acc = sat(m_acc); end
      2'd2: begin m_miss = sat(m_miss); m_acc = sat(m_acc); end
      default: m_viol = sat(m_viol);
    endcase
  endtask

  task automatic tick();
    exp_v = req_valid;
    if (req_valid) predict();
    if (wr_en) begin
      m_v[wr_idx] = wr_valid; m_vpn[wr_idx] = wr_vpn; m_asn[wr_idx] = wr_asn;
      m_pfn[wr_idx] = wr_pfn; m_x[wr_idx] = wr_xmask;
    end
    @(posedge clk);
    @(negedge clk);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'(exp_v));
    if (exp_v) begin
      check(exp_tag, "code", 64'(rsp_code), 64'(exp_code));
      check((exp_code != 2'd0) ? "R9" : exp_tag, "pa", 64'(rsp_pa), 64'(exp_pa));
    end
    check("R10", "cnt_hit",  64'(cnt_hit),  64'(m_hit));
    check("R10", "cnt_miss", 64'(cnt_miss), 64'(m_miss));
    check("R10", "cnt_viol", 64'(cnt_viol), 64'(m_viol));
    check("R11", "cnt_access", 64'(cnt_access), 64'(m_acc));
    req_valid = 1'b0;
    wr_en     = 1'b0;
    force_tag = "";
  endtask

  task automatic rq(logic [63:0] va, logic [63:0] pc, logic [1:0] mode, logic [7:0] asn);
    req_valid = 1'b1; req_va = va; req_pc = pc; req_mode = mode; req_asn = asn;
  endtask

  task automatic wr(int idx, logic [34:0] vpn, logic [7:0] asn, logic [30:0] pfn,
                    logic v, logic [3:0] x);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = vpn; wr_asn = asn;
    wr_pfn = pfn; wr_valid = v; wr_xmask = x;
  endtask

  localparam logic [63:0] VA_T = 64'h0000_1234_5678_A9C4;
  localparam logic [63:0] PC_E = 64'h0000_0000_0010_0000;

  initial begin
    for (int i = 0; i < ENT; i++) begin
      m_v[i] = 1'b0; m_vpn[i] = '0; m_asn[i] = '0; m_pfn[i] = '0; m_x[i] = '0;
    end
    m_hit = 0; m_miss = 0; m_viol = 0; m_acc = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_pc = '0; req_mode = '0; req_asn = '0;
    wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_asn = '0; wr_pfn = '0; wr_valid = 1'b0;
    wr_xmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R10", "reset cnt_hit", 64'(cnt_hit), 64'd0);
    tick();

    // R2: privileged PC, non-canonical VA still hits
    rq(64'h1234_5678_9ABC_DEF7, 64'h0000_0000_0002_0001, 2'd3, 8'd0); tick();
    // R3: same VA from a normal PC
    rq(64'h1234_5678_9ABC_DEF7, PC_E, 2'd0, 8'd0); tick();
    // R4: superpage in kernel, bit 40 set and clear
    rq(64'hFFFF_FD23_4567_89A8, PC_E, 2'd0, 8'd0); tick();
    rq(64'hFFFF_FC12_3456_7890, PC_E, 2'd0, 8'd0); tick();
    tick();
    // R5: superpage in other modes
    for (int m = 1; m < 4; m++) begin
      rq(64'hFFFF_FD23_4567_89A8, PC_E, 2'(m), 8'd0); tick();
    end
    // R7: empty table
    rq(VA_T, PC_E, 2'd0, 8'd5); tick();
    // R12: write and lookup in the same cycle
    wr(3, VA_T[47:13], 8'd5, 31'h1ABC_DE01, 1'b1, 4'b1001);
    rq(VA_T, PC_E, 2'd0, 8'd5); force_tag = "R12"; tick();
    // R6 / R8 per mode
    for (int m = 0; m < 4; m++) begin
      rq(VA_T, PC_E, 2'(m), 8'd5); tick();
    end
    // R7: address-space mismatch
    rq(VA_T, PC_E, 2'd0, 8'd6); tick();
    // R6: lower index duplicate wins
    wr(1, VA_T[47:13], 8'd5, 31'h0055_AA11, 1'b1, 4'b1111); tick();
    rq(VA_T, PC_E, 2'd1, 8'd5); tick();
    rq(VA_T, PC_E, 2'd0, 8'd5); tick();
    // invalidate lower entry: back to index 3
    wr(1, VA_T[47:13], 8'd5, 31'h0055_AA11, 1'b0, 4'b1111); tick();
    rq(VA_T, PC_E, 2'd0, 8'd5); tick();
    rq(VA_T, PC_E, 2'd1, 8'd5); tick();
    // R10 / R11 saturation
    for (int k = 0; k < 300; k++) begin
      rq(64'(k) << 4, 64'h1, 2'd3, 8'd0); tick();
    end
    rq(VA_T, PC_E, 2'd0, 8'd9); force_tag = "R11"; tick();
    tick();

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule